// File: doc/BRIEF.md
# Serial Flash Continuous-Read Sequencer

This block sits on the host side of a single-line SPI link to a serial flash. It takes one read request and runs the whole transaction. A request carries a page number, a byte offset within that page, a byte count, a choice between the fast read command and the legacy read command, and a choice between 264-byte and 256-byte page geometry. The block lowers chip select and shifts out the command byte, a 24-bit address packed for the chosen geometry, and the filler bytes that the command needs. It then clocks in the requested number of data bytes, raises chip select, and reports completion.

Received bytes leave the block on a valid/ready stream. When the consumer holds off, the serial clock freezes, so no byte is ever lost. A read that runs past the end of a page is issued as one command, because the flash carries on into the next page by itself. The serial clock is made from the system clock by a parameterised divider and follows SPI mode 0.

Top module: `sfr_seq`

## Requirements
- R1: With req_legacy = 0 the block sends command byte 0x0B, then three address bytes, then one filler byte: 40 SCK rising edges come before the first data bit.
- R2: With req_legacy = 1 the block sends command byte 0xE8, then three address bytes, then four filler bytes: 64 SCK rising edges come before the first data bit.
- R3: With req_bin = 0 (264-byte pages) the 24-bit address carries the page in bits 18..9 and the 9-bit offset in bits 8..0, with bits 23..19 zero.
- R4: With req_bin = 1 (256-byte pages) the address carries the page in bits 17..8 and offset bits 7..0 in bits 7..0. Offset bit 8 and address bits 23..18 are sent as zero.
- R5: All bits move MSB first in SPI mode 0. SCK is low whenever chip select is high. MOSI changes only on a falling SCK edge while chip select is low. MISO is sampled on the rising edge. Each SCK half-period lasts DIV system clocks.
- R6: Each accepted request produces exactly one low period on spi_cs_n. That period contains exactly header + 8 x req_len rising SCK edges, including reads that cross page boundaries.
- R7: Data bytes appear on rd_data in the order they are read, each assembled MSB first from MISO and marked by rd_valid. While rd_valid is high and rd_ready is low, rd_data holds and SCK does not toggle.
- R8: When spi_cs_n rises, SCK is already low. spi_cs_n then stays high for at least two system clocks before done pulses. done is a single cycle, comes only after the last byte has been accepted, and coincides with req_ready returning high.
- R9: A request is taken only while req_ready is high. A req_valid pulse during a transaction starts nothing and does not change the transaction in progress.
- R10: A request with req_len = 0 is ignored: chip select stays high and done does not pulse.
- R11: During and after reset, spi_cs_n is high, SCK is low, rd_valid and done are low, and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | High while the block is idle |
| req_page | input | PAGE_W | Page number |
| req_offset | input | OFF_W | Starting byte within the page |
| req_len | input | LEN_W | Number of bytes to read; 0 is ignored |
| req_legacy | input | 1 | 0: fast command with one filler byte; 1: legacy command with four filler bytes |
| req_bin | input | 1 | 0: 264-byte pages; 1: 256-byte pages |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| rd_valid | output | 1 | Data byte valid |
| rd_ready | input | 1 | Consumer accepts the byte |
| rd_data | output | 8 | Received byte |
| done | output | 1 | One-cycle pulse when the transaction has ended |

## Verification
The bench includes a flash model that decodes the command and the address from the captured MOSI bits and serves bytes from a computed memory. A wrong filler count or wrong address packing therefore shows up twice: as a wrong header field, and as shifted or foreign data. Several cases exercise the address handling. One read crosses a 264-byte page boundary; a design that issued a new command there would show two chip-select windows. Another sets offset bit 8 in 256-byte mode; a design that does not mask it would send a different address. The bench also applies a stalling consumer, under which a design that kept clocking would drop or overwrite bytes. Finally it sends a request while the block is busy and a zero-length request; a design that honoured either would open an extra chip-select window or pulse done.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_TAIL,
        ST_GAP
    } sfr_state_e;

    localparam logic [7:0] OP_FAST   = 8'h0B;
    localparam logic [7:0] OP_LEGACY = 8'hE8;
    localparam int         HDR_FAST_BITS   = 40;
    localparam int         HDR_LEGACY_BITS = 64;
    localparam int         SR_W = 64;
endpackage

// File: rtl/sfr_addr_pack.sv
module sfr_addr_pack #(
    parameter int PAGE_W = 10,
    parameter int OFF_W  = 9,
    parameter int ADDR_W = 24
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [OFF_W-1:0]  offset,
    input  logic              bin_geom,
    output logic [ADDR_W-1:0] addr
);
    // 264-byte pages use the full offset; 256-byte pages drop its top bit.
    always_comb begin
        if (bin_geom) begin
            addr = ADDR_W'({page, offset[OFF_W-2:0]});
        end else begin
            addr = ADDR_W'({page, offset});
        end
    end
endmodule

// File: rtl/sfr_clkdiv.sv
module sfr_clkdiv #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!en) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(DIV - 1)) begin
            tick  = 1'b1;
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5: the half-period counter never passes its limit
    a_r5_div_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DIV - 1));
endmodule

// File: rtl/sfr_seq.sv
module sfr_seq
    import sfr_pkg::*;
#(
    parameter int DIV    = 2,
    parameter int LEN_W  = 12,
    parameter int PAGE_W = 10,
    parameter int OFF_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_legacy,
    input  logic              req_bin,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [7:0]        rd_data,
    output logic              done
);
    localparam int ADDR_W = 24;
    localparam int CNT_W  = LEN_W + 4;

    typedef struct packed {
        sfr_state_e       st;
        logic             cs_n;
        logic             sck;
        logic [SR_W-1:0]  tx;
        logic [7:0]       rx;
        logic [7:0]       rd;
        logic             rv;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hdr;
        logic [CNT_W-1:0] total;
        logic             gap;
        logic             done;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic [ADDR_W-1:0] addr_w;
    logic              div_en;
    logic              tick;
    logic [CNT_W-1:0]  cnt_nx;
    logic [CNT_W-1:0]  hdr_nx;
    logic              stall;

    sfr_addr_pack #(
        .PAGE_W (PAGE_W),
        .OFF_W  (OFF_W),
        .ADDR_W (ADDR_W)
    ) u_pack (
        .page     (req_page),
        .offset   (req_offset),
        .bin_geom (req_bin),
        .addr     (addr_w)
    );

    sfr_clkdiv #(.DIV(DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (div_en),
        .tick  (tick)
    );

    assign stall  = r_q.rv && !rd_ready;
    assign div_en = ((r_q.st == ST_SHIFT) || (r_q.st == ST_TAIL)) && !stall;
    assign cnt_nx = r_q.cnt + 1'b1;
    assign hdr_nx = req_legacy ? CNT_W'(HDR_LEGACY_BITS) : CNT_W'(HDR_FAST_BITS);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (r_q.rv && rd_ready) r_d.rv = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.cs_n = 1'b1;
                r_d.sck  = 1'b0;
                if (req_valid && (req_len != '0)) begin
                    r_d.st    = ST_SHIFT;
                    r_d.cs_n  = 1'b0;
                    r_d.cnt   = '0;
                    r_d.hdr   = hdr_nx;
                    r_d.total = hdr_nx + CNT_W'({req_len, 3'b000});
                    if (req_legacy) r_d.tx = {OP_LEGACY, addr_w, 32'h0};
                    else            r_d.tx = {OP_FAST, addr_w, 8'h0, 24'h0};
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!r_q.sck) begin
                        r_d.sck = 1'b1;
                        r_d.rx  = {r_q.rx[6:0], spi_miso};
                        r_d.cnt = cnt_nx;
                        if ((cnt_nx > r_q.hdr) && (cnt_nx[2:0] == 3'd0)) begin
                            r_d.rd = {r_q.rx[6:0], spi_miso};
                            r_d.rv = 1'b1;
                        end
                        if (cnt_nx == r_q.total) r_d.st = ST_TAIL;
                    end else begin
                        r_d.sck = 1'b0;
                        r_d.tx  = r_q.tx << 1;
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    r_d.sck  = 1'b0;
                    r_d.cs_n = 1'b1;
                    r_d.tx   = '0;
                    r_d.gap  = 1'b0;
                    r_d.st   = ST_GAP;
                end
            end
            ST_GAP: begin
                r_d.gap = 1'b1;
                if (r_q.gap && !r_d.rv) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.cs_n  <= 1'b1;
            r_q.sck   <= 1'b0;
            r_q.tx    <= '0;
            r_q.rx    <= '0;
            r_q.rd    <= '0;
            r_q.rv    <= 1'b0;
            r_q.cnt   <= '0;
            r_q.hdr   <= '0;
            r_q.total <= '0;
            r_q.gap   <= 1'b0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign spi_cs_n  = r_q.cs_n;
    assign spi_sck   = r_q.sck;
    assign spi_mosi  = r_q.tx[SR_W-1];
    assign rd_valid  = r_q.rv;
    assign rd_data   = r_q.rd;
    assign done      = r_q.done;

    // R5: within a select window MOSI only moves on a falling SCK edge
    a_r5_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && $past(!spi_cs_n) && !$fell(spi_sck)) |-> $stable(spi_mosi));

    // R5: SCK idles low outside a select window
    a_r5_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R7: a pending byte holds and the serial clock freezes
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(spi_sck)));

    // R8: deselect lasts at least two system clocks
    a_r8_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |=> spi_cs_n ##1 spi_cs_n);

    // R8: done only in idle with the stream drained
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && spi_cs_n && !rd_valid));

    // R9: the request side is open only while deselected
    a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> spi_cs_n);
endmodule

// File: tb/tb_sfr_seq.sv
module tb_sfr_seq;
    localparam int DIV    = 2;
    localparam int LEN_W  = 12;
    localparam int PAGE_W = 10;
    localparam int OFF_W  = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [PAGE_W-1:0] req_page = '0;
    logic [OFF_W-1:0]  req_offset = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              req_legacy = 1'b0;
    logic              req_bin = 1'b0;
    logic              spi_cs_n, spi_sck, spi_mosi;
    logic              spi_miso = 1'b0;
    logic              rd_valid;
    logic              rd_ready = 1'b1;
    logic [7:0]        rd_data;
    logic              done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int done_cnt = 0;
    bit bp = 1'b0;

    // flash model state
    int          rise_cnt = 0;
    int          cs_windows = 0;
    int          hdr_len = 64;
    logic [63:0] hdr_bits = '0;
    bit          m_bin = 1'b0;
    int unsigned m_start = 0;
    int unsigned m_size = 1;
    int          cs_rise_cyc = 0;

    logic [7:0] expq[$];

    sfr_seq #(.DIV(DIV), .LEN_W(LEN_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_page(req_page), .req_offset(req_offset), .req_len(req_len),
        .req_legacy(req_legacy), .req_bin(req_bin), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .done(done)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] memb(input int unsigned idx);
        logic [31:0] t;
        t = idx * 29 + (idx >> 8) * 7 + 32'h3C;
        return t[7:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // flash model: header capture on rising SCK, data drive on falling SCK
    always @(negedge spi_cs_n) begin
        rise_cnt = 0;
        cs_windows++;
        hdr_bits = '0;
        hdr_len = 64;
        spi_miso = 1'b0;
    end

    always @(posedge spi_cs_n) cs_rise_cyc = cyc;

    always @(posedge spi_sck) begin
        if (spi_cs_n === 1'b0) begin
            logic [23:0] a;
            if (rise_cnt < 64) hdr_bits[63 - rise_cnt] = spi_mosi;
            rise_cnt++;
            if (rise_cnt == 8) hdr_len = (hdr_bits[63:56] == 8'h0B) ? 40 : 64;
            if (rise_cnt == 32) begin
                a = hdr_bits[55:32];
                m_start = m_bin ? int'(a[17:0]) : int'(a[18:9]) * 264 + int'(a[8:0]);
            end
        end
    end

    always @(negedge spi_sck) begin
        if (spi_cs_n === 1'b0 && rise_cnt >= hdr_len) begin
            int k;
            logic [7:0] b;
            k = rise_cnt - hdr_len;
            b = memb((m_start + k / 8) % m_size);
            spi_miso = b[7 - (k % 8)];
        end
    end

    // monitor: chooses rd_ready and scores bytes accepted at the next edge
    always @(negedge clk) begin
        cyc++;
        if (done) done_cnt++;
        rd_ready = bp ? ((cyc % 3) == 0) : 1'b1;
        if (rst_n && rd_valid && rd_ready) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R7 unexpected byte", rd_data, 0);
            end else begin
                logic [7:0] e;
                e = expq.pop_front();
                chk(rd_data == e, "R7 data byte", rd_data, e);
            end
        end
    end

    task automatic run(input int page, input int off, input int len, input bit legacy,
                       input bit bin, input bit bp_on, input bit inject);
        logic [23:0] ea;
        logic [PAGE_W-1:0] pg;
        logic [OFF_W-1:0]  of;
        int unsigned st;
        int w0, d0, hl;
        pg = PAGE_W'(page);
        of = OFF_W'(off);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        m_bin = bin;
        bp = bp_on;
        m_size = bin ? 262144 : 1024 * 264;
        ea = bin ? {6'b0, pg, of[7:0]} : {5'b0, pg, of};
        st = bin ? int'(ea[17:0]) : int'(pg) * 264 + int'(of);
        for (int i = 0; i < len; i++) expq.push_back(memb((st + i) % m_size));
        hl = legacy ? 64 : 40;
        w0 = cs_windows;
        d0 = done_cnt;
        req_page = pg; req_offset = of; req_len = LEN_W'(len);
        req_legacy = legacy; req_bin = bin; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (inject) begin
            repeat (10) @(negedge clk);
            chk(!req_ready, "R9 busy during transfer", req_ready, 0);
            req_page = 5; req_offset = 1; req_len = 2; req_legacy = 0; req_bin = 0;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(hdr_bits[63:56] == (legacy ? 8'hE8 : 8'h0B), legacy ? "R2 opcode" : "R1 opcode",
            hdr_bits[63:56], legacy ? 8'hE8 : 8'h0B);
        chk(hdr_bits[55:32] == ea, bin ? "R4 address" : "R3 address", hdr_bits[55:32], ea);
        chk(rise_cnt == hl + 8 * len, legacy ? "R2 filler and data edges" : "R1 filler and data edges",
            rise_cnt, hl + 8 * len);
        chk(cs_windows - w0 == 1, "R6 single select window", cs_windows - w0, 1);
        chk(expq.size() == 0, "R7 all bytes delivered", expq.size(), 0);
        chk(req_ready && spi_cs_n && !spi_sck, "R8 idle at done", {req_ready, spi_cs_n, spi_sck}, 3'b110);
        chk(cyc - cs_rise_cyc >= 2, "R8 deselect gap", cyc - cs_rise_cyc, 2);
        @(negedge clk);
        chk(!done && done_cnt - d0 == 1, "R8 done single pulse", done_cnt - d0, 1);
        if (inject) begin
            repeat (20) @(negedge clk);
            chk(cs_windows - w0 == 1 && spi_cs_n, "R9 busy request ignored", cs_windows - w0, 1);
        end
        bp = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(spi_cs_n && !spi_sck && !rd_valid && !done && req_ready, "R11 in reset",
            {spi_cs_n, spi_sck, rd_valid, done, req_ready}, 5'b10001);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(spi_cs_n && !spi_sck && !rd_valid && !done && req_ready, "R11 after reset",
            {spi_cs_n, spi_sck, rd_valid, done, req_ready}, 5'b10001);

        // R1 R3 R5: fast command, 264-byte pages, free-running consumer
        run(3, 5, 4, 1'b0, 1'b0, 1'b0, 1'b0);
        // R2 R6 R9: legacy command crossing a page end, stalling consumer, busy request
        run(7, 260, 8, 1'b1, 1'b0, 1'b1, 1'b1);
        // R4: 256-byte pages with offset bit 8 set, stalling consumer
        run(1023, 9'h1FE, 3, 1'b0, 1'b1, 1'b1, 1'b0);
        // R2 R4: legacy command, single byte
        run(9'h155, 0, 1, 1'b1, 1'b1, 1'b0, 1'b0);
        // R3 R6: last byte of the last 264-byte page
        run(1023, 263, 2, 1'b0, 1'b0, 1'b0, 1'b0);

        // R10: zero-length request
        begin
            int w0, d0;
            bit cs_ok;
            w0 = cs_windows;
            d0 = done_cnt;
            cs_ok = 1'b1;
            @(negedge clk);
            req_len = '0; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (!spi_cs_n) cs_ok = 1'b0;
            end
            chk(cs_ok && cs_windows == w0, "R10 zero length no select", cs_windows - w0, 0);
            chk(done_cnt == d0 && req_ready, "R10 zero length no done", done_cnt - d0, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule